// File: doc/BRIEF.md
# Quad-lane windowed burst SPI slave

This block is the slave end of a four-lane SPI link that carries a half-duplex burst inside one chip-select frame. Once chip select goes low, the slave counts rising SCLK edges and splits the frame into a series of slots. An optional lead-in of clocks is skipped. A write slot follows, in which the master sends one nibble per clock. Then come idle turnaround clocks, and then a reply slot in which the slave drives one nibble per clock back on the same four lines.

Each slave gets its own lead-in count. Several slaves on one bus can therefore share a single long master frame, with each one listening and answering in a slot of its own. SCLK idles low (mode 0). The master samples on rising edges, and the slave changes its reply on falling edges.

SCLK, chip select and the data lanes are resynchronised into the system clock. The system clock has to run at least eight times faster than SCLK. The slot lengths and the reply word are taken when chip select falls. The received nibbles are presented as one word when the write slot completes.

Top module: `qwin_burst_slave`

## Requirements
- R1: After reset, io_oe is 0, io_out is 0, rx_word is 0, and neither rx_done nor frame_err pulses.
- R2: cfg_skip, cfg_wr_len, cfg_dummy, cfg_rd_len and reply_word are captured at the falling edge of cs_n. Changing them later in the frame has no effect on that frame.
- R3: Rising SCLK edges are numbered k = 0, 1, ... from the falling edge of cs_n. Edges k = cfg_skip + j, for j below the write length, sample io_in into rx_word[4j+3:4j]. The nibbles of rx_word above the write length read 0. rx_word is updated together with a one-cycle rx_done pulse after the last write nibble, and this happens once per frame.
- R4: io_in values on edges outside the write slot do not reach rx_word.
- R5: io_oe is 0 on every clock before the reply slot, which covers the lead-in, the write slot and the cfg_dummy turnaround clocks.
- R6: The reply slot begins at edge rs = cfg_skip + write length + cfg_dummy. For the rising edge rs + j, the slave drives reply_word[4j+3:4j] with io_oe = 4'hF. The value is set up after the preceding falling edge.
- R7: io_oe returns to 0 after the falling edge that follows the last reply clock, so the next rising edge sees it released.
- R8: When cs_n rises, io_oe drops to 0 within three system clocks, including in the middle of the reply slot.
- R9: A frame that ends before its last write nibble is sampled produces one frame_err pulse and no rx_done pulse, and leaves rx_word unchanged.
- R10: A write or read length of 0 is treated as 1, and a length above NIB is treated as NIB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI clock from the master, idle low |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 4 | Data lanes as seen at the pads |
| io_out | output | 4 | Reply nibble driven onto the lanes |
| io_oe | output | 4 | Per-lane output enable |
| cfg_skip | input | SKIP_W | Lead-in clocks before the write slot |
| cfg_wr_len | input | $clog2(NIB)+1 | Write slot length in nibbles |
| cfg_dummy | input | GAP_W | Turnaround clocks between the slots |
| cfg_rd_len | input | $clog2(NIB)+1 | Reply slot length in nibbles |
| reply_word | input | 4*NIB | Reply data, nibble j in bits 4j+3:4j |
| rx_word | output | 4*NIB | Received data, nibble j in bits 4j+3:4j |
| rx_done | output | 1 | One-cycle pulse when rx_word is refreshed |
| frame_err | output | 1 | One-cycle pulse for a truncated frame |

## Verification
Every pad change takes two synchroniser stages and then one register, so a new reply nibble appears about three system clocks after the SCLK fall. The bench drives each SCLK half period as five system clocks and reads io_out and io_oe on the last system clock of the low half, which is where a master would sample. The release of io_oe is checked three clocks after cs_n rises. The rx_done and frame_err pulses land within four clocks of the causing edge. The bench counts these pulses continuously and compares the counts, together with rx_word, six clocks after every frame closes.

// File: rtl/qwin_pkg.sv
package qwin_pkg;

  // Slot a given rising-edge index falls into
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_WRITE,
    PH_GAP,
    PH_REPLY,
    PH_TAIL
  } phase_e;

  // Edge events seen in the system clock domain
  typedef struct packed {
    logic rise;      // SCLK rising while selected
    logic fall;      // SCLK falling while selected
    logic cs_start;  // chip select asserted
    logic cs_end;    // chip select released
  } edge_ev_t;

endpackage

// File: rtl/qwin_sync.sv
module qwin_sync #(
  parameter int               W       = 6,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/qwin_edges.sv
module qwin_edges
  import qwin_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s,
  input  logic     cs_s,
  output edge_ev_t ev
);

  logic sclk_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  always_comb begin
    ev.rise     = sclk_s & ~sclk_d & ~cs_s;
    ev.fall     = ~sclk_s & sclk_d & ~cs_s;
    ev.cs_start = ~cs_s & cs_d;
    ev.cs_end   = cs_s & ~cs_d;
  end

endmodule

// File: rtl/qwin_sched.sv
module qwin_sched
  import qwin_pkg::*;
#(
  parameter int NIB    = 8,
  parameter int SKIP_W = 6,
  parameter int GAP_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  edge_ev_t                ev,
  input  logic [SKIP_W-1:0]       cfg_skip,
  input  logic [$clog2(NIB):0]    cfg_wr_len,
  input  logic [GAP_W-1:0]        cfg_dummy,
  input  logic [$clog2(NIB):0]    cfg_rd_len,
  output logic                    wr_stb,
  output logic [$clog2(NIB)-1:0]  wr_idx,
  output logic                    wr_last,
  output logic                    drv_stb,
  output logic [$clog2(NIB)-1:0]  drv_idx,
  output logic                    drv_end,
  output logic                    frame_err
);

  localparam int IW = $clog2(NIB);
  localparam int LW = IW + 1;
  localparam int MW = (SKIP_W > GAP_W) ? SKIP_W : GAP_W;
  localparam int CW = MW + LW + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] wb_q, wb_d, we_q, we_d, rs_q, rs_d, re_q, re_d;
  logic          act_q, act_d;
  logic          wdone_q, wdone_d;
  logic          err_q, err_d;
  logic          bnd_en;
  phase_e        ph_now;

  function automatic logic [LW-1:0] clamp_len(input logic [LW-1:0] v);
    if (v == '0)         return LW'(1);
    if (v > LW'(NIB))    return LW'(NIB);
    return v;
  endfunction

  function automatic phase_e phase_of(input logic [CW-1:0] k,
                                      input logic [CW-1:0] wb,
                                      input logic [CW-1:0] we,
                                      input logic [CW-1:0] rs,
                                      input logic [CW-1:0] re);
    if (k < wb)      return PH_LEAD;
    else if (k < we) return PH_WRITE;
    else if (k < rs) return PH_GAP;
    else if (k < re) return PH_REPLY;
    return PH_TAIL;
  endfunction

  // Slot boundaries from the configuration present at chip select
  always_comb begin
    wb_d = CW'(cfg_skip);
    we_d = wb_d + CW'(clamp_len(cfg_wr_len));
    rs_d = we_d + CW'(cfg_dummy);
    re_d = rs_d + CW'(clamp_len(cfg_rd_len));
  end

  assign ph_now = act_q ? phase_of(cnt_q, wb_q, we_q, rs_q, re_q) : PH_IDLE;

  // Rising edge k uses cnt_q = k; falling edge after rise f sees cnt_q = f+1
  assign wr_stb  = ev.rise & (ph_now == PH_WRITE);
  assign wr_idx  = IW'(cnt_q - wb_q);
  assign wr_last = wr_stb & (cnt_q == (we_q - CW'(1)));
  assign drv_stb = ev.fall & (ph_now == PH_REPLY);
  assign drv_idx = IW'(cnt_q - rs_q);
  assign drv_end = ev.fall & act_q & (cnt_q == re_q);

  assign bnd_en = ev.cs_start;

  always_comb begin
    cnt_d   = cnt_q;
    act_d   = act_q;
    wdone_d = wdone_q;
    err_d   = 1'b0;
    if (ev.cs_start) begin
      cnt_d   = '0;
      act_d   = 1'b1;
      wdone_d = 1'b0;
    end else if (act_q) begin
      if (ev.rise && (cnt_q != '1)) cnt_d = cnt_q + CW'(1);
      if (wr_last) wdone_d = 1'b1;
      if (ev.cs_end) begin
        act_d = 1'b0;
        err_d = ~wdone_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      wdone_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      wdone_q <= wdone_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q <= '0;
      we_q <= '0;
      rs_q <= '0;
      re_q <= '0;
    end else if (bnd_en) begin
      wb_q <= wb_d;
      we_q <= we_d;
      rs_q <= rs_d;
      re_q <= re_d;
    end
  end

  assign frame_err = err_q;

endmodule

// File: rtl/qwin_data.sv
module qwin_data #(
  parameter int NIB = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic                    frame_stop,
  input  logic                    cs_s,
  input  logic [3:0]              io_s,
  input  logic [4*NIB-1:0]        reply_word,
  input  logic                    wr_stb,
  input  logic [$clog2(NIB)-1:0]  wr_idx,
  input  logic                    wr_last,
  input  logic                    drv_stb,
  input  logic [$clog2(NIB)-1:0]  drv_idx,
  input  logic                    drv_end,
  output logic [4*NIB-1:0]        rx_word,
  output logic                    rx_done,
  output logic [3:0]              io_out,
  output logic [3:0]              io_oe
);

  localparam int IW = $clog2(NIB);
  localparam int DW = 4 * NIB;

  logic [DW-1:0]  stage_q, stage_d;
  logic [DW-1:0]  rx_q;
  logic [DW-1:0]  rep_q;
  logic [NIB-1:0] hit;
  logic           done_q;
  logic [3:0]     nib_q, nib_d;
  logic           oe_q, oe_d;
  logic           stage_en, nib_en;

  // Staging buffer, one lane-group per nibble slot
  for (genvar j = 0; j < NIB; j++) begin : g_nib
    assign hit[j] = wr_stb & (wr_idx == IW'(j));
    assign stage_d[4*j +: 4] = frame_start ? 4'h0 :
                               (hit[j] ? io_s : stage_q[4*j +: 4]);
  end

  assign stage_en = frame_start | wr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  // Published word: only a completed write slot reaches it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_q <= '0;
    else if (wr_last) rx_q <= stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= wr_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rep_q <= '0;
    else if (frame_start) rep_q <= reply_word;
  end

  // Reply lane driver
  assign nib_d  = rep_q[{drv_idx, 2'b00} +: 4];
  assign nib_en = drv_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nib_q <= 4'h0;
    else if (nib_en) nib_q <= nib_d;
  end

  always_comb begin
    oe_d = oe_q;
    if (frame_start | frame_stop | drv_end) oe_d = 1'b0;
    else if (drv_stb)                       oe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= oe_d;
  end

  assign io_oe   = {4{oe_q & ~cs_s}};
  assign io_out  = (oe_q & ~cs_s) ? nib_q : 4'h0;
  assign rx_word = rx_q;
  assign rx_done = done_q;

endmodule

// File: rtl/qwin_burst_slave.sv
module qwin_burst_slave
  import qwin_pkg::*;
#(
  parameter int NIB    = 8,
  parameter int SKIP_W = 6,
  parameter int GAP_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic [3:0]            io_in,
  output logic [3:0]            io_out,
  output logic [3:0]            io_oe,
  input  logic [SKIP_W-1:0]     cfg_skip,
  input  logic [$clog2(NIB):0]  cfg_wr_len,
  input  logic [GAP_W-1:0]      cfg_dummy,
  input  logic [$clog2(NIB):0]  cfg_rd_len,
  input  logic [4*NIB-1:0]      reply_word,
  output logic [4*NIB-1:0]      rx_word,
  output logic                  rx_done,
  output logic                  frame_err
);

  localparam int IW = $clog2(NIB);
  localparam int PW = 6;

  logic [1:0]    rst_pipe;
  logic          rst_q;
  logic [PW-1:0] pad_s;
  logic          cs_s, sclk_s;
  logic [3:0]    io_s;
  edge_ev_t      ev;

  logic          wr_stb, wr_last, drv_stb, drv_end;
  logic [IW-1:0] wr_idx, drv_idx;

  // Reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  qwin_sync #(
    .W       (PW),
    .STAGES  (SYNC_N),
    .RST_VAL (6'b100000)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .d     ({cs_n, sclk, io_in}),
    .q     (pad_s)
  );

  assign cs_s   = pad_s[5];
  assign sclk_s = pad_s[4];
  assign io_s   = pad_s[3:0];

  qwin_edges u_edges (
    .clk    (clk),
    .rst_n  (rst_q),
    .sclk_s (sclk_s),
    .cs_s   (cs_s),
    .ev     (ev)
  );

  qwin_sched #(
    .NIB    (NIB),
    .SKIP_W (SKIP_W),
    .GAP_W  (GAP_W)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_q),
    .ev         (ev),
    .cfg_skip   (cfg_skip),
    .cfg_wr_len (cfg_wr_len),
    .cfg_dummy  (cfg_dummy),
    .cfg_rd_len (cfg_rd_len),
    .wr_stb     (wr_stb),
    .wr_idx     (wr_idx),
    .wr_last    (wr_last),
    .drv_stb    (drv_stb),
    .drv_idx    (drv_idx),
    .drv_end    (drv_end),
    .frame_err  (frame_err)
  );

  qwin_data #(
    .NIB (NIB)
  ) u_data (
    .clk         (clk),
    .rst_n       (rst_q),
    .frame_start (ev.cs_start),
    .frame_stop  (ev.cs_end),
    .cs_s        (cs_s),
    .io_s        (io_s),
    .reply_word  (reply_word),
    .wr_stb      (wr_stb),
    .wr_idx      (wr_idx),
    .wr_last     (wr_last),
    .drv_stb     (drv_stb),
    .drv_idx     (drv_idx),
    .drv_end     (drv_end),
    .rx_word     (rx_word),
    .rx_done     (rx_done),
    .io_out      (io_out),
    .io_oe       (io_oe)
  );

endmodule

// File: rtl/qwin_burst_slave_chk.sv
module qwin_burst_slave_chk #(
  parameter int NIB = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_s,
  input logic             sclk_s,
  input logic [3:0]       io_out,
  input logic [3:0]       io_oe,
  input logic [4*NIB-1:0] rx_word,
  input logic             rx_done,
  input logic             frame_err
);

  // R3: one refresh per frame, never two in a row
  a_r3_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R4: the published word moves only together with rx_done
  a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> rx_done);

  // R9: error pulse follows a released chip select and excludes rx_done
  a_r9_err_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($past(cs_s) && !rx_done));

  // R6: reply lanes change only after SCLK was seen low
  a_r6_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_oe != 4'h0) && !$stable(io_out)) |-> !$past(sclk_s));

  // R5: all four lanes turn around together
  a_r5_oe_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0) || (io_oe == 4'hF));

endmodule

bind qwin_burst_slave qwin_burst_slave_chk #(.NIB(NIB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_s      (cs_s),
  .sclk_s    (sclk_s),
  .io_out    (io_out),
  .io_oe     (io_oe),
  .rx_word   (rx_word),
  .rx_done   (rx_done),
  .frame_err (frame_err)
);

// File: tb/sim_qwin_burst_slave.sv
`timescale 1ns/1ps
module sim_qwin_burst_slave;

  localparam int NIB  = 8;
  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic [3:0]  io_in = 4'h0;
  logic [3:0]  io_out, io_oe;
  logic [5:0]  cfg_skip = '0;
  logic [3:0]  cfg_wr_len = '0;
  logic [3:0]  cfg_dummy = '0;
  logic [3:0]  cfg_rd_len = '0;
  logic [31:0] reply_word = '0;
  logic [31:0] rx_word;
  logic        rx_done, frame_err;

  int n_cmp = 0;
  int n_bad = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  bit finished = 1'b0;
  logic [31:0] last_rx = '0;

  always #10 clk = ~clk;

  qwin_burst_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .cfg_skip(cfg_skip),
    .cfg_wr_len(cfg_wr_len), .cfg_dummy(cfg_dummy), .cfg_rd_len(cfg_rd_len),
    .reply_word(reply_word), .rx_word(rx_word), .rx_done(rx_done),
    .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rx_done)   done_cnt++;
    if (frame_err) err_cnt++;
  end

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_len(input int v);
    if (v == 0) return 1;
    if (v > NIB) return NIB;
    return v;
  endfunction

  task automatic run_frame(input int skip, input int wl, input int dm,
                           input int rl, input int ncyc, input bit chg);
    int ewl = eff_len(wl);
    int erl = eff_len(rl);
    int wb = skip;
    int we = skip + ewl;
    int rs = we + dm;
    int re = rs + erl;
    logic [31:0] wdata = $urandom;
    logic [31:0] rep = $urandom;
    logic [31:0] exp_rx;
    logic [63:0] mask;
    int d0 = done_cnt;
    int e0 = err_cnt;
    cfg_skip = 6'(skip);
    cfg_wr_len = 4'(wl);
    cfg_dummy = 4'(dm);
    cfg_rd_len = 4'(rl);
    reply_word = rep;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    if (chg) begin
      // R2: late changes must not alter this frame
      cfg_skip = 6'(skip + 3);
      cfg_wr_len = 4'(ewl == 1 ? 5 : 1);
      cfg_dummy = 4'(dm + 2);
      cfg_rd_len = 4'(erl == 1 ? 6 : 2);
      reply_word = ~rep;
    end
    for (int k = 0; k < ncyc; k++) begin
      io_in = (k >= wb && k < we) ? wdata[4*(k-wb) +: 4] : 4'($urandom);
      repeat (HALF) @(negedge clk);
      if (k >= rs && k < re) begin
        check(io_oe == 4'hF, "R6 oe in reply", 64'(io_oe), 64'hF);
        check(io_out == rep[4*(k-rs) +: 4], chg ? "R2/R6 reply nibble" : "R6 reply nibble",
              64'(io_out), 64'(rep[4*(k-rs) +: 4]));
      end else if (k >= re) begin
        check(io_oe == 4'h0, "R7 oe after reply", 64'(io_oe), 64'h0);
      end else begin
        check(io_oe == 4'h0, "R5 oe before reply", 64'(io_oe), 64'h0);
      end
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    if (ncyc >= rs && ncyc < re) begin
      check(io_oe == 4'hF, "R6 oe before release", 64'(io_oe), 64'hF);
      cs_n = 1'b1;
      repeat (3) @(negedge clk);
      check(io_oe == 4'h0, "R8 oe on cs release", 64'(io_oe), 64'h0);
    end else begin
      cs_n = 1'b1;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    if (ncyc >= we) begin
      mask = (64'd1 << (4 * ewl)) - 64'd1;
      exp_rx = wdata & mask[31:0];
      check(rx_word == exp_rx, "R3/R4 rx_word", 64'(rx_word), 64'(exp_rx));
      check(done_cnt == d0 + 1, "R3 rx_done count", 64'(done_cnt - d0), 64'd1);
      check(err_cnt == e0, "R9 no error", 64'(err_cnt - e0), 64'd0);
      last_rx = exp_rx;
    end else begin
      check(rx_word == last_rx, "R9 rx_word kept", 64'(rx_word), 64'(last_rx));
      check(done_cnt == d0, "R9 no rx_done", 64'(done_cnt - d0), 64'd0);
      check(err_cnt == e0 + 1, "R9 error pulse", 64'(err_cnt - e0), 64'd1);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7331));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(io_oe == 4'h0, "R1 oe", 64'(io_oe), 64'h0);
    check(io_out == 4'h0, "R1 io_out", 64'(io_out), 64'h0);
    check(rx_word == 32'h0, "R1 rx_word", 64'(rx_word), 64'h0);
    check(done_cnt == 0 && err_cnt == 0, "R1 pulses", 64'(done_cnt + err_cnt), 64'h0);

    run_frame(0, 4, 2, 4, 12, 1'b0);   // plain frame with trailing clocks
    run_frame(5, 3, 0, 2, 11, 1'b0);   // offset slot, no turnaround
    run_frame(2, 8, 3, 8, 23, 1'b0);   // full lengths
    run_frame(1, 6, 1, 3, 4, 1'b0);    // R9 cut inside write slot
    run_frame(0, 2, 1, 1, 0, 1'b0);    // R9 no clocks at all
    run_frame(3, 2, 2, 6, 9, 1'b0);    // R8 cut inside reply slot
    run_frame(0, 0, 1, 15, 12, 1'b0);  // R10 zero and oversize lengths
    run_frame(4, 12, 0, 0, 15, 1'b0);  // R10 oversize write, zero read
    run_frame(2, 3, 2, 4, 13, 1'b1);   // R2 late config change
    run_frame(0, 1, 15, 1, 18, 1'b0);  // long turnaround
    for (int i = 0; i < 24; i++) begin
      int s = int'($urandom_range(20, 0));
      int w = int'($urandom_range(15, 0));
      int d = int'($urandom_range(6, 0));
      int r = int'($urandom_range(15, 0));
      int tot = s + eff_len(w) + d + eff_len(r) + 2;
      run_frame(s, w, d, r, int'($urandom_range(tot, 0)), 1'(($urandom & 3) == 0));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule